// File: doc/BRIEF.md
# Serial Configuration Port with Staged Latches

This block is the control port of a fractional-N synthesizer. Configuration words arrive one bit at a time on a slow serial clock and are gathered in a 21-bit shift register. A write strobe moves the gathered word into the holding registers that feed the divider counters and the modulator. A second, separate strobe loads a 20-bit enhancement register. Those bits only reach the outside while the active-low enhancement input is held low. A direct-select input bypasses the serial path so that the counter values come straight from parallel pins.

The serial clock, the serial data and both strobes are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are found in the system domain. Writes are staged in two steps. A word whose top bit is 0 only fills a 20-bit staging register. A word whose top bit is 1 loads the 21-bit primary register, and in the same cycle it copies the staging register into the active fractional register. Integer and fractional settings therefore change together.

The serial source sets its own timing and cannot be stalled, so the port has no valid/ready handshake and applies no back-pressure. Every input is a plain level. The source must respect the ordering rules: serial data stays stable around each rising edge of the serial clock, each strobe rises only after the last serial clock edge of its word, and the serial clock does not rise again until the strobe has fallen. Each of these signals must stay stable for at least three system clocks.

Top module: `scp_port`

## Requirements
- R1: After reset every counter output (m_o, a_o, r_o, k_o), mod_ord_o, dither_o, aux_o and dout_o is 0.
- R2: Each rising edge of the serial clock shifts the sampled data bit into bit 0 of the 21-bit shift register, so a word is sent MSB first. Falling edges shift nothing.
- R3: A write strobe rising edge while shift-register bit 20 is 0 copies bits 19:0 into the staging register. The counter, K, order and dither outputs do not change.
- R4: A write strobe rising edge while bit 20 is 1 loads the primary register in one system clock. It sets M = bits 19:11, A = bits 10:7, R = bits 6:1 and dither = bit 0. In the same cycle it copies the staging register into the active register, setting K = staging bits 17:0 and modulator order = staging bits 19:18.
- R5: An enhancement strobe rising edge copies shift-register bits 19:0 into the enhancement register and leaves all counter outputs unchanged.
- R6: aux_o shows the enhancement register while enh_n_i is 0 and is all zeros while enh_n_i is 1.
- R7: dout_o equals shift-register bit 20 (the oldest bit held) while enh_n_i is 0, and is 0 while enh_n_i is 1.
- R8: While direct_i is 1, m_o, a_o, r_o and k_o follow dir_m_i, dir_a_i, dir_r_i and dir_k_i, and mod_ord_o and dither_o are 0. When direct_i returns to 0, the latched values are shown again.
- R9: A strobe that arrives after an incomplete word acts on whatever the shift register currently holds, following R3/R4. No error is signalled.
- R10: The registers update on the third rising edge of the system clock after a synchronized edge is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, sampled on serial clock rise |
| wr_stb_i | input | 1 | Write strobe (staging or commit) |
| enh_stb_i | input | 1 | Enhancement register load strobe |
| enh_n_i | input | 1 | Enhancement enable, active low |
| direct_i | input | 1 | Selects parallel pins for counter values |
| dir_m_i | input | 9 | Direct M value |
| dir_a_i | input | 4 | Direct A value |
| dir_r_i | input | 6 | Direct R value |
| dir_k_i | input | 18 | Direct K value |
| m_o | output | 9 | Main counter value |
| a_o | output | 4 | Swallow counter value |
| r_o | output | 6 | Reference counter value |
| k_o | output | 18 | Fractional value |
| mod_ord_o | output | 2 | Modulator order select |
| dither_o | output | 1 | K LSB toggle enable |
| aux_o | output | 20 | Gated enhancement bits |
| dout_o | output | 1 | Serial data out in enhancement mode |

## Verification
The assertions check on every cycle that the shift register, the staging register, the primary register and the enhancement register change only on their own synchronized edges. They also check that a commit copies the previous staging value into the active register, that a loaded primary register always carries its commit flag, and that aux_o and dout_o are quiet while the enhancement input is high. Only the bench's scenarios can show the rest: the field positions, the MSB-first bit order, the atomic change of integer and fractional values, the direct-pin bypass, and the handling of a partial word.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;
  // Lane positions inside the synchronizer bus.
  localparam int LN_CLK  = 0;
  localparam int LN_WR   = 1;
  localparam int LN_ENH  = 2;
  localparam int LN_DAT  = 3;
  localparam int LANES   = 4;
  // Lanes that need edge detection (clock and both strobes).
  localparam int EDGE_LANES = 3;
endpackage

// File: rtl/scp_sync.sv
`timescale 1ns/1ps
module scp_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  logic [STAGES-1:0][N-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/scp_edge.sv
`timescale 1ns/1ps
module scp_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rise
      assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end
  endgenerate

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R10
endmodule

// File: rtl/scp_shift.sv
`timescale 1ns/1ps
module scp_shift #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         bit_i,
  input  logic         enh_act_i,
  output logic [W-1:0] word_o,
  output logic         dout_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (step_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign word_o = sh_q;
  assign dout_o = enh_act_i & sh_q[W-1];

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(sh_q)); // R2
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (sh_q[W-1:1] == $past(sh_q[W-2:0]))); // R2
endmodule

// File: rtl/scp_latch.sv
`timescale 1ns/1ps
module scp_latch #(
  parameter int M_W   = 9,
  parameter int A_W   = 4,
  parameter int R_W   = 6,
  parameter int K_W   = 18,
  parameter int ORD_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_rise_i,
  input  logic                     enh_rise_i,
  input  logic [M_W+A_W+R_W+1:0]   word_i,
  output logic [M_W-1:0]           m_q,
  output logic [A_W-1:0]           a_q,
  output logic [R_W-1:0]           r_q,
  output logic                     dith_q,
  output logic [K_W-1:0]           k_q,
  output logic [ORD_W-1:0]         ord_q,
  output logic [K_W+ORD_W-1:0]     aux_q
);
  localparam int WORD_W = M_W + A_W + R_W + 2;
  localparam int SEC_W  = K_W + ORD_W;
  localparam int R_LO   = 1;
  localparam int A_LO   = R_LO + R_W;
  localparam int M_LO   = A_LO + A_W;

  logic [WORD_W-1:0] pri_q;
  logic [SEC_W-1:0]  stg_q;
  logic [SEC_W-1:0]  act_q;
  logic [SEC_W-1:0]  enh_q;
  logic              commit;

  assign commit = word_i[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      stg_q <= '0;
      act_q <= '0;
    end else if (wr_rise_i) begin
      if (commit) begin
        pri_q <= word_i;
        act_q <= stg_q;
      end else begin
        stg_q <= word_i[SEC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          enh_q <= '0;
    else if (enh_rise_i) enh_q <= word_i[SEC_W-1:0];
  end

  assign m_q    = pri_q[M_LO +: M_W];
  assign a_q    = pri_q[A_LO +: A_W];
  assign r_q    = pri_q[R_LO +: R_W];
  assign dith_q = pri_q[0];
  assign k_q    = act_q[K_W-1:0];
  assign ord_q  = act_q[SEC_W-1:K_W];
  assign aux_q  = enh_q;

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise_i |=> $stable(stg_q)); // R3
  AST_STAGE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise_i && !commit) |=> ($stable(act_q) && $stable(pri_q))); // R3
  AST_PRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise_i |=> ($stable(pri_q) && $stable(act_q))); // R4
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise_i && commit) |=> (act_q == $past(stg_q))); // R4
  AST_PRI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_q != '0) |-> pri_q[WORD_W-1]); // R4
  AST_ENH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_rise_i |=> $stable(enh_q)); // R5
endmodule

// File: rtl/scp_port.sv
`timescale 1ns/1ps
module scp_port #(
  parameter int M_W         = 9,
  parameter int A_W         = 4,
  parameter int R_W         = 6,
  parameter int K_W         = 18,
  parameter int ORD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk_i,
  input  logic                 ser_data_i,
  input  logic                 wr_stb_i,
  input  logic                 enh_stb_i,
  input  logic                 enh_n_i,
  input  logic                 direct_i,
  input  logic [M_W-1:0]       dir_m_i,
  input  logic [A_W-1:0]       dir_a_i,
  input  logic [R_W-1:0]       dir_r_i,
  input  logic [K_W-1:0]       dir_k_i,
  output logic [M_W-1:0]       m_o,
  output logic [A_W-1:0]       a_o,
  output logic [R_W-1:0]       r_o,
  output logic [K_W-1:0]       k_o,
  output logic [ORD_W-1:0]     mod_ord_o,
  output logic                 dither_o,
  output logic [K_W+ORD_W-1:0] aux_o,
  output logic                 dout_o
);
  import scp_pkg::*;

  localparam int WORD_W = M_W + A_W + R_W + 2;
  localparam int SEC_W  = K_W + ORD_W;

  logic [LANES-1:0]      raw;
  logic [LANES-1:0]      lvl;
  logic [EDGE_LANES-1:0] rise;
  logic [WORD_W-1:0]     word;
  logic                  enh_act;

  logic [M_W-1:0]   lm;
  logic [A_W-1:0]   la;
  logic [R_W-1:0]   lr;
  logic             ld;
  logic [K_W-1:0]   lk;
  logic [ORD_W-1:0] lo;
  logic [SEC_W-1:0] laux;

  always_comb begin
    raw         = '0;
    raw[LN_CLK] = ser_clk_i;
    raw[LN_WR]  = wr_stb_i;
    raw[LN_ENH] = enh_stb_i;
    raw[LN_DAT] = ser_data_i;
  end

  assign enh_act = ~enh_n_i;

  scp_sync #(.N(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw),
    .lvl_o  (lvl)
  );

  scp_edge #(.N(EDGE_LANES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl[EDGE_LANES-1:0]),
    .rise_o(rise)
  );

  scp_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (rise[LN_CLK]),
    .bit_i    (lvl[LN_DAT]),
    .enh_act_i(enh_act),
    .word_o   (word),
    .dout_o   (dout_o)
  );

  scp_latch #(.M_W(M_W), .A_W(A_W), .R_W(R_W), .K_W(K_W), .ORD_W(ORD_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_rise_i (rise[LN_WR]),
    .enh_rise_i(rise[LN_ENH]),
    .word_i    (word),
    .m_q       (lm),
    .a_q       (la),
    .r_q       (lr),
    .dith_q    (ld),
    .k_q       (lk),
    .ord_q     (lo),
    .aux_q     (laux)
  );

  always_comb begin
    if (direct_i) begin
      m_o       = dir_m_i;
      a_o       = dir_a_i;
      r_o       = dir_r_i;
      k_o       = dir_k_i;
      mod_ord_o = '0;
      dither_o  = 1'b0;
    end else begin
      m_o       = lm;
      a_o       = la;
      r_o       = lr;
      k_o       = lk;
      mod_ord_o = lo;
      dither_o  = ld;
    end
  end

  assign aux_o = enh_act ? laux : '0;

  AST_AUX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    enh_n_i |-> (aux_o == '0)); // R6
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    enh_n_i |-> !dout_o); // R7
endmodule

// File: tb/sim_scp_port.sv
`timescale 1ns/1ps
module sim_scp_port;
  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, ser_data, wr_stb, enh_stb, enh_n, direct;
  logic [8:0]  dm;
  logic [3:0]  da;
  logic [5:0]  dr;
  logic [17:0] dk;
  logic [8:0]  m_o;
  logic [3:0]  a_o;
  logic [5:0]  r_o;
  logic [17:0] k_o;
  logic [1:0]  ord_o;
  logic        dith_o;
  logic [19:0] aux_o;
  logic        dout_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Requirement-level model state.
  logic [20:0] sh_m  = '0;
  logic [19:0] stg_m = '0;
  logic [19:0] act_m = '0;
  logic [20:0] pri_m = '0;
  logic [19:0] aux_m = '0;

  always #10 clk = ~clk;

  scp_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .wr_stb_i(wr_stb), .enh_stb_i(enh_stb), .enh_n_i(enh_n), .direct_i(direct),
    .dir_m_i(dm), .dir_a_i(da), .dir_r_i(dr), .dir_k_i(dk),
    .m_o(m_o), .a_o(a_o), .r_o(r_o), .k_o(k_o), .mod_ord_o(ord_o),
    .dither_o(dith_o), .aux_o(aux_o), .dout_o(dout_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b; wt(3);
    ser_clk = 1'b1; wt(4);
    ser_clk = 1'b0; wt(3);
    sh_m = {sh_m[19:0], b};
  endtask

  task automatic send_bits(input logic [20:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic pulse_wr();
    wt(2); wr_stb = 1'b1; wt(4); wr_stb = 1'b0; wt(4);
    if (sh_m[20]) begin pri_m = sh_m; act_m = stg_m; end
    else stg_m = sh_m[19:0];
  endtask

  task automatic pulse_enh();
    wt(2); enh_stb = 1'b1; wt(4); enh_stb = 1'b0; wt(4);
    aux_m = sh_m[19:0];
  endtask

  task automatic check_latched(input string req);
    chk({req, " m"},   32'(m_o),    32'(pri_m[19:11]));
    chk({req, " a"},   32'(a_o),    32'(pri_m[10:7]));
    chk({req, " r"},   32'(r_o),    32'(pri_m[6:1]));
    chk({req, " dith"},32'(dith_o), 32'(pri_m[0]));
    chk({req, " k"},   32'(k_o),    32'(act_m[17:0]));
    chk({req, " ord"}, 32'(ord_o),  32'(act_m[19:18]));
  endtask

  task automatic t_reset();
    check_latched("R1 reset");
    chk("R1 aux", 32'(aux_o), 0);
    chk("R1 dout", 32'(dout_o), 0);
    enh_n = 1'b0; wt(1);
    chk("R1 aux enh", 32'(aux_o), 0);
    chk("R1 dout enh", 32'(dout_o), 0);
    enh_n = 1'b1; wt(1);
  endtask

  task automatic t_stage();
    send_bits({1'b0, 2'b10, 18'h2A5C3}, 21);
    pulse_wr();
    chk("R3 m unchanged", 32'(m_o), 0);
    chk("R3 k unchanged", 32'(k_o), 0);
    chk("R3 ord unchanged", 32'(ord_o), 0);
  endtask

  task automatic t_commit();
    send_bits({1'b1, 9'h15B, 4'hA, 6'h2D, 1'b1}, 21);
    pulse_wr();
    chk("R4 m", 32'(m_o), 32'h15B);
    chk("R4 a", 32'(a_o), 32'hA);
    chk("R4 r", 32'(r_o), 32'h2D);
    chk("R4 dith", 32'(dith_o), 1);
    chk("R4 k", 32'(k_o), 32'h2A5C3);
    chk("R4 ord", 32'(ord_o), 2);
  endtask

  task automatic t_shift_dout();
    enh_n = 1'b0;
    send_bits(21'h1FFFFF, 21);
    chk("R7 dout ones", 32'(dout_o), 1);
    enh_n = 1'b1; wt(1);
    chk("R7 dout gated", 32'(dout_o), 0);
    enh_n = 1'b0;
    for (int i = 0; i < 24; i++) begin
      shift_bit(i[0] ^ i[2]);
      chk("R2 dout follows order", 32'(dout_o), 32'(sh_m[20]));
    end
    // A lone rising edge shifts; the following falling edge must not.
    ser_data = 1'b0; wt(3); ser_clk = 1'b1; wt(4);
    sh_m = {sh_m[19:0], 1'b0};
    chk("R2 rise shifts", 32'(dout_o), 32'(sh_m[20]));
    ser_data = ~sh_m[19]; ser_clk = 1'b0; wt(6);
    chk("R2 fall no shift", 32'(dout_o), 32'(sh_m[20]));
    enh_n = 1'b1; wt(1);
  endtask

  task automatic t_aux();
    send_bits({1'b1, 20'hC3A5F}, 21);
    pulse_enh();
    chk("R6 aux gated", 32'(aux_o), 0);
    enh_n = 1'b0; wt(1);
    chk("R5 aux loaded", 32'(aux_o), 32'hC3A5F);
    check_latched("R5 no counter effect");
    enh_n = 1'b1; wt(1);
    chk("R6 aux off again", 32'(aux_o), 0);
  endtask

  task automatic t_direct();
    dm = 9'h0A7; da = 4'h5; dr = 6'h11; dk = 18'h1F00D;
    direct = 1'b1; wt(1);
    chk("R8 m", 32'(m_o), 32'h0A7);
    chk("R8 a", 32'(a_o), 5);
    chk("R8 r", 32'(r_o), 32'h11);
    chk("R8 k", 32'(k_o), 32'h1F00D);
    chk("R8 ord", 32'(ord_o), 0);
    chk("R8 dith", 32'(dith_o), 0);
    direct = 1'b0; wt(1);
    check_latched("R8 back to latched");
  endtask

  task automatic t_partial();
    // Five bits only: the word held is partly old content.
    send_bits(21'h13, 5);
    pulse_wr();
    check_latched("R9 partial word");
    send_bits(21'h2, 3);
    pulse_wr();
    check_latched("R9 second partial");
    send_bits({1'b1, 20'h5A5A5}, 21);
    pulse_wr();
    check_latched("R9 R4 full after partial");
  endtask

  task automatic t_latency();
    // R10: edge presented, register updates on the third clock edge.
    send_bits({1'b0, 2'b01, 18'h00F0F}, 21);
    pulse_wr();
    send_bits({1'b1, 9'h1C3, 4'h3, 6'h0C, 1'b0}, 21);
    @(negedge clk); wr_stb = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 not yet", 32'(m_o), 32'(pri_m[19:11]));
    @(posedge clk); #1;
    chk("R10 updated", 32'(m_o), 32'h1C3);
    chk("R10 k with it", 32'(k_o), 32'h00F0F);
    wt(2); wr_stb = 1'b0; wt(4);
    pri_m = sh_m; act_m = stg_m;
    check_latched("R10 settled");
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 0; ser_data = 0; wr_stb = 0; enh_stb = 0;
    enh_n = 1'b1; direct = 0; dm = '0; da = '0; dr = '0; dk = '0;
    wt(5); rst_n = 1'b1; wt(3);
    t_reset();
    t_stage();
    t_commit();
    t_shift_dout();
    t_aux();
    t_direct();
    t_partial();
    t_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule